// File: doc/BRIEF.md
# S/PDIF Subframe Biphase Transmitter

This block converts a stream of 27-bit subframe words into a biphase-mark-coded serial line. Each word carries a 24-bit audio sample together with the channel-status, user and validity bits. Words enter through a valid/ready handshake into a small internal FIFO. On each subframe boundary the transmitter takes one word, emits an 8-half-bit sync preamble, then the 27 payload bits least significant bit first, then an even-parity bit. Each payload or parity bit is coded as two half-bit cells.

The serial line advances by exactly one half-bit on every cycle where the `half_en` clock enable is high. Subframes alternate between channel A and channel B. The transmitter counts frames within a block so that frame 0 of every block carries the block-start preamble in place of the plain channel-A preamble. If no word is waiting when a subframe must begin, the block still sends a properly framed all-zero subframe and raises a sticky underrun flag. A dedicated input clears that flag.

Top module: `spdif_bmc_tx`

## Requirements
- R1: After reset `sdo` equals the `LINE_INIT` level (0 by default), `underrun` is 0 and `in_ready` is 1.
- R2: Word bits [23:0] hold the sample with bit 23 as its MSB, bit 24 is validity, bit 25 is user and bit 26 is channel status; payload bits go out in the order bit 0, bit 1, … bit 26, beginning right after the preamble.
- R3: Each subframe starts with 8 preamble half-bits sent left to right: when the preceding line half-bit was 0 these are 11101000 (block start), 11100100 (channel B) and 11100010 (channel A); when it was 1, they are the bitwise inverses.
- R4: Every payload and parity bit takes two half-bits: the first half inverts the previous line level, and the second half inverts it again for a 1 and holds it for a 0.
- R5: The 28th bit cell carries parity, which is 1 when bits [26:0] hold an odd count of ones and 0 otherwise, so the line ends each subframe at the level it had before the preamble.
- R6: Subframes alternate A, B, A, B from reset; the A subframe of frame 0 in every block of `FRAMES_PER_BLOCK` (192) frames uses the block-start preamble, and the frame count wraps from 191 to 0.
- R7: `in_ready` stays high while fewer than `FIFO_DEPTH` words are queued; a word is accepted when `in_valid` and `in_ready` are both high, a word offered while `in_ready` is low is dropped, and words go out in acceptance order.
- R8: When a subframe starts with the FIFO empty, the block sends an all-zero payload with parity 0 and sets `underrun`. The flag stays set until `clr_underrun` is high, and a new underrun in the same cycle as a clear leaves it set.
- R9: `sdo` changes only on a rising edge where `half_en` is high, and a subframe spans exactly 64 such enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Half-bit clock enable; one line half-bit per pulse |
| in_word | input | 27 | Subframe word: status, user, validity, 24-bit sample |
| in_valid | input | 1 | Word offered on `in_word` |
| in_ready | output | 1 | FIFO has room for a word |
| clr_underrun | input | 1 | Clears the sticky underrun flag |
| sdo | output | 1 | Biphase-mark coded serial line |
| underrun | output | 1 | Sticky flag: a subframe started with no word queued |

## Verification
Each half-bit is registered, so the level set up by a `half_en` pulse is on `sdo` just after that rising edge. The bench samples `sdo` at the falling edge that follows it and assembles 64 samples per subframe before comparing them against a stream it builds itself from the word, the expected preamble and the start level. The underrun flag settles at the same edge as the first preamble half-bit, so the flag is read only after that half-bit has been captured. `in_ready` drops at the edge that stores the last free slot, so it is checked one falling edge after the final push.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int PAYLOAD_W  = 27;
    localparam int CELL_COUNT = PAYLOAD_W + 1;
    localparam int PRE_HALVES = 8;
    localparam int SUB_HALVES = PRE_HALVES + 2 * CELL_COUNT;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_CHA   = 2'd1,
        SYNC_CHB   = 2'd2
    } sync_kind_e;

    // One half-bit request to the line coder
    typedef struct packed {
        logic is_sync;
        logic sync_level;
        logic cell_bit;
        logic late_half;
    } half_sym_t;

    // Preamble as sent after a low line level, leftmost half-bit first
    function automatic logic [7:0] sync_pattern(input sync_kind_e kind);
        logic [7:0] pat;
        case (kind)
            SYNC_BLOCK: pat = 8'b1110_1000;
            SYNC_CHB:   pat = 8'b1110_0100;
            default:    pat = 8'b1110_0010;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/spdif_word_fifo.sv
module spdif_word_fifo #(
    parameter int DEPTH = 4,
    parameter int WORD_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push;

    always_comb begin
        st_d = st_q;
        push = wr_valid && (st_q.cnt != FULL_CNT);
        if (push) begin
            st_d.mem[st_q.wr] = wr_word;
            st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        end
        if (rd_pop) begin
            st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, rd_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready = (st_q.cnt != FULL_CNT);
    assign rd_empty = (st_q.cnt == '0);
    assign rd_word  = st_q.mem[st_q.rd];

    // R7: the sequencer never takes a word from an empty queue
    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> !rd_empty);

endmodule

// File: rtl/spdif_bmc_coder.sv
module spdif_bmc_coder #(
    parameter logic LINE_INIT = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  spdif_tx_pkg::half_sym_t sym,
    output logic                    line
);

    logic line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (step) begin
            if (sym.is_sync) begin
                line_d = sym.sync_level;
            end else if (!sym.late_half) begin
                line_d = ~line_q;
            end else if (sym.cell_bit) begin
                line_d = ~line_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LINE_INIT;
        end else begin
            line_q <= line_d;
        end
    end

    assign line = line_q;

    // R9: the line only moves on a half-bit enable
    a_r9_line_holds_between_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(line_q));

endmodule

// File: rtl/spdif_subframe_seq.sv
module spdif_subframe_seq #(
    parameter int   FRAMES_PER_BLOCK = 192,
    parameter logic LINE_INIT = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 half_en,
    input  logic                                 q_empty,
    input  logic [spdif_tx_pkg::PAYLOAD_W-1:0]   q_word,
    input  logic                                 clr_flag,
    input  logic                                 line_now,
    output logic                                 q_pop,
    output spdif_tx_pkg::half_sym_t              sym,
    output logic                                 flag_underrun
);

    import spdif_tx_pkg::*;

    localparam int SLOT_W  = $clog2(SUB_HALVES);
    localparam int FRAME_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
    localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(SUB_HALVES - 1);
    localparam logic [SLOT_W-1:0]  SYNC_END   = SLOT_W'(PRE_HALVES);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES_PER_BLOCK - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]     slot;
        logic                  chan_b;
        logic [FRAME_W-1:0]    frame;
        sync_kind_e            kind;
        logic                  pol;
        logic [CELL_COUNT-1:0] cells;
        logic                  urun;
    } seq_st_t;

    seq_st_t    st_d, st_q;
    logic       at_start;
    sync_kind_e kind_now;
    logic       pol_now;
    logic [7:0] pat;
    logic [2:0] sync_idx;

    always_comb begin
        st_d     = st_q;
        q_pop    = 1'b0;
        at_start = (st_q.slot == '0);

        if (!at_start) begin
            kind_now = st_q.kind;
        end else if (st_q.chan_b) begin
            kind_now = SYNC_CHB;
        end else if (st_q.frame == '0) begin
            kind_now = SYNC_BLOCK;
        end else begin
            kind_now = SYNC_CHA;
        end
        pol_now  = at_start ? line_now : st_q.pol;
        pat      = sync_pattern(kind_now);
        sync_idx = st_q.slot[2:0];

        sym.is_sync    = (st_q.slot < SYNC_END);
        sym.sync_level = pat[3'd7 - sync_idx] ^ pol_now;
        sym.cell_bit   = st_q.cells[0];
        sym.late_half  = st_q.slot[0];

        // clear first, so a fresh underrun in the same cycle wins
        st_d.urun = st_q.urun & ~clr_flag;

        if (half_en) begin
            if (at_start) begin
                st_d.kind = kind_now;
                st_d.pol  = pol_now;
                if (!q_empty) begin
                    q_pop      = 1'b1;
                    st_d.cells = {^q_word, q_word};
                end else begin
                    st_d.cells = '0;
                    st_d.urun  = 1'b1;
                end
            end else if (!sym.is_sync && sym.late_half) begin
                st_d.cells = {1'b0, st_q.cells[CELL_COUNT-1:1]};
            end

            if (st_q.slot == LAST_SLOT) begin
                st_d.slot   = '0;
                st_d.chan_b = ~st_q.chan_b;
                if (st_q.chan_b) begin
                    st_d.frame = (st_q.frame == LAST_FRAME) ? '0 : st_q.frame + 1'b1;
                end
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= SYNC_BLOCK;
            st_q.pol  <= LINE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_underrun = st_q.urun;

    // R3: every preamble opens with a level change on the line
    a_r3_sync_opens_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && st_q.slot == '0) |=> (line_now != $past(line_now)));

    // R5: parity brings the line back to the level seen before the preamble
    a_r5_level_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && st_q.slot == LAST_SLOT) |=> (line_now == st_q.pol));

    // R6: frame position stays inside the block
    a_r6_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame <= LAST_FRAME);

    // R8: an empty queue at a subframe start raises the flag
    a_r8_flag_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (half_en && st_q.slot == '0 && q_empty) |=> st_q.urun);

    // R8: the flag is sticky until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.urun && !clr_flag) |=> st_q.urun);

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx #(
    parameter int   FIFO_DEPTH       = 4,
    parameter int   FRAMES_PER_BLOCK = 192,
    parameter logic LINE_INIT        = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        half_en,
    input  logic [26:0] in_word,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        clr_underrun,
    output logic        sdo,
    output logic        underrun
);

    import spdif_tx_pkg::*;

    logic                 q_pop;
    logic                 q_empty;
    logic [PAYLOAD_W-1:0] q_word;
    half_sym_t            sym;
    logic                 line;

    spdif_word_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .WORD_W (PAYLOAD_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_word  (in_word),
        .wr_valid (in_valid),
        .wr_ready (in_ready),
        .rd_pop   (q_pop),
        .rd_word  (q_word),
        .rd_empty (q_empty)
    );

    spdif_subframe_seq #(
        .FRAMES_PER_BLOCK (FRAMES_PER_BLOCK),
        .LINE_INIT        (LINE_INIT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_en       (half_en),
        .q_empty       (q_empty),
        .q_word        (q_word),
        .clr_flag      (clr_underrun),
        .line_now      (line),
        .q_pop         (q_pop),
        .sym           (sym),
        .flag_underrun (underrun)
    );

    spdif_bmc_coder #(
        .LINE_INIT (LINE_INIT)
    ) u_coder (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (half_en),
        .sym   (sym),
        .line  (line)
    );

    assign sdo = line;

endmodule

// File: tb/sim_spdif_bmc_tx.sv
module sim_spdif_bmc_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_en = 1'b0;
    logic [26:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        clr_underrun = 1'b0;
    logic        in_ready, sdo, underrun;
    logic        in_ready1, sdo1, underrun1;

    int n_chk = 0;
    int n_bad = 0;
    int sub_idx = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spdif_bmc_tx u0 (
        .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_word(in_word),
        .in_valid(in_valid), .in_ready(in_ready), .clr_underrun(clr_underrun),
        .sdo(sdo), .underrun(underrun)
    );

    spdif_bmc_tx #(.LINE_INIT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_word(in_word),
        .in_valid(1'b0), .in_ready(in_ready1), .clr_underrun(clr_underrun),
        .sdo(sdo1), .underrun(underrun1)
    );

    // word, expected parity bit
    localparam logic [27:0] VEC [8] = '{
        {27'h0000001, 1'b1}, {27'h0000003, 1'b0}, {27'h7FFFFFF, 1'b1},
        {27'h4000000, 1'b1}, {27'h1000000, 1'b1}, {27'h0FFFFFF, 1'b0},
        {27'h0A5A5A5, 1'b0}, {27'h2800001, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 block start, 1 channel A, 2 channel B
    function automatic int kind_of(input int idx);
        if (idx % 2 == 1) return 2;
        if ((idx / 2) % 192 == 0) return 0;
        return 1;
    endfunction

    function automatic logic [63:0] expect_stream(input logic [26:0] w, input logic par,
                                                  input int kind, input logic start);
        logic [7:0]  pat;
        logic [63:0] v;
        logic        lvl;
        logic        b;
        case (kind)
            0:       pat = 8'b11101000;
            2:       pat = 8'b11100100;
            default: pat = 8'b11100010;
        endcase
        for (int i = 0; i < 8; i++) v[63-i] = pat[7-i] ^ start;
        lvl = v[56];
        for (int c = 0; c < 28; c++) begin
            b = (c < 27) ? w[c] : par;
            lvl = ~lvl;
            v[55-2*c] = lvl;
            if (b) lvl = ~lvl;
            v[54-2*c] = lvl;
        end
        return v;
    endfunction

    task automatic half_step(input bit clr);
        @(negedge clk);
        half_en = 1'b1;
        clr_underrun = clr;
        @(negedge clk);
        half_en = 1'b0;
        clr_underrun = 1'b0;
    endtask

    task automatic run_sub(output logic [63:0] g0, output logic [63:0] g1,
                           input int gap_at, input bit clr_first);
        logic held;
        for (int i = 0; i < 64; i++) begin
            half_step(clr_first && i == 0);
            if (i == gap_at) begin
                held = sdo;
                repeat (7) @(negedge clk);
                check(sdo == held, "R9 line held without enable", {63'd0, sdo}, {63'd0, held});
            end
            g0[63-i] = sdo;
            g1[63-i] = sdo1;
        end
        sub_idx++;
    endtask

    task automatic push(input logic [26:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic sub_and_check(input logic [26:0] w, input logic par, input int gap,
                                 input bit clr, input string req);
        logic [63:0] g0, g1, e;
        int k;
        k = kind_of(sub_idx);
        run_sub(g0, g1, gap, clr);
        e = expect_stream(w, par, k, 1'b0);
        check(g0 == e, req, g0, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] g0, g1, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(sdo == 1'b0, "R1 sdo after reset", {63'd0, sdo}, 64'd0);
        check(underrun == 1'b0, "R1 underrun after reset", {63'd0, underrun}, 64'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
        check(sdo1 == 1'b1, "R1 sdo with high rest level", {63'd0, sdo1}, 64'd1);

        // vector table: R2 bit order, R4 coding, R5 parity, R6 A/B order
        for (int i = 0; i < 8; i++) begin
            push(VEC[i][27:1]);
            run_sub(g0, g1, (i == 2) ? 20 : -1, 1'b0);
            e = expect_stream(VEC[i][27:1], VEC[i][0], kind_of(sub_idx - 1), 1'b0);
            check(g0 == e, "R2 R4 R5 R6 table subframe", g0, e);
            if (i == 0) begin
                e = expect_stream(27'd0, 1'b0, 0, 1'b1);
                check(g1 == e, "R3 inverted block-start after high level", g1, e);
            end
        end
        check(underrun == 1'b0, "R8 no underrun while fed", {63'd0, underrun}, 64'd0);

        // R7 fill the queue, offer an extra word while full
        for (int i = 0; i < 4; i++) push(VEC[i][27:1]);
        check(in_ready == 1'b0, "R7 ready low when full", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        in_valid = 1'b1;
        in_word = VEC[7][27:1];
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sub_and_check(VEC[i][27:1], VEC[i][0], -1, 1'b0, "R7 queued order");
            if (i == 0) check(in_ready == 1'b1, "R7 ready back after pop", {63'd0, in_ready}, 64'd1);
        end

        // R8 dropped word means empty queue: zero subframe and flag
        sub_and_check(27'd0, 1'b0, -1, 1'b0, "R8 zero subframe on underrun");
        check(underrun == 1'b1, "R8 flag set", {63'd0, underrun}, 64'd1);

        push(VEC[6][27:1]);
        sub_and_check(VEC[6][27:1], VEC[6][0], -1, 1'b0, "R8 normal subframe after underrun");
        check(underrun == 1'b1, "R8 flag sticky", {63'd0, underrun}, 64'd1);

        @(negedge clk);
        clr_underrun = 1'b1;
        @(negedge clk);
        clr_underrun = 1'b0;
        check(underrun == 1'b0, "R8 flag cleared", {63'd0, underrun}, 64'd0);

        // R8 set wins over clear at a starving subframe start
        sub_and_check(27'd0, 1'b0, -1, 1'b1, "R8 zero subframe with clear");
        check(underrun == 1'b1, "R8 set wins over clear", {63'd0, underrun}, 64'd1);

        // R6 run through the block wrap on starved subframes
        while (sub_idx < 388) begin
            sub_and_check(27'd0, 1'b0, -1, 1'b0, "R6 block position preamble");
        end
        check(kind_of(384) == 0, "R6 frame 192 starts a block", 64'(kind_of(384)), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule